// File: doc/BRIEF.md
# Command-Aware Nibble Scrambler

This block sits in a transmit path ahead of the line coder. It takes a stream of nibbles, each tagged as data, escape or command code. Data nibbles are XORed with a four-bit window of a 10-bit linear feedback shift register. Escape and code nibbles leave the block unchanged. The generator moves four bit positions for every nibble that leaves the block, whatever its kind.

On a start-of-cell request the block inserts a two-nibble command ahead of the cell. The first nibble is always an escape. The second is another escape when the generator has run through its full 1023-state cycle since its last reload. Otherwise it is code 4. An escape that directly follows another escape reloads the generator to all ones. This gives the far end a known point to lock its descrambler to. After reset the first inserted command is always the escape-escape form.

Top module: `cmd_nib_scrambler`

## Requirements
- R1: Kind tags are 2'b00 data, 2'b01 escape and 2'b10 code. An accepted data nibble appears on the output one clock later, still tagged data, as `in ^ mask`. Mask bit i is X(t-i), where X(t) is the newest bit of the sequence a(n) = a(n-7) ^ a(n-10), a 10-bit generator with polynomial x^10 + x^7 + 1.
- R2: The generator advances four sequence positions for every nibble the block emits, of any kind. It holds its state in cycles with no output (`out_valid_o` low).
- R3: Escape and code nibbles are emitted with their value and kind unchanged.
- R4: When `sof_req_i` is high and no command is being inserted, `in_ready_o` is low in that cycle and in the next. The block emits an escape with value 0 one clock after the request, then the command's second nibble one clock after that.
- R5: The second nibble of an inserted command depends on how many nibbles have been emitted since the last reload, counting the command's first escape. If that count is at least 1023, the second nibble is an escape with value 0. Otherwise it is code 4.
- R6: Emitting an escape directly after an emitted escape reloads the generator to all ones. From that point the masks run 1111, 0000, 0001, 1100, one per emitted nibble.
- R7: In the run escape, escape, escape, code 8, the third escape reloads the generator again. Code 8 is emitted at the all-ones state, so the data nibble after it uses mask 0000.
- R8: While `rst_ni` is low, `out_valid_o` is 0 and the generator is all ones. The first start-of-cell request after reset produces escape, escape.
- R9: After exactly 1023 emitted nibbles since a reload, the generator is back at all ones, so the next data nibble is XORed with 1111.
- R10: The nibble count keeps running across cells that start with escape, code 4. A request made after the count reaches 1023 gets escape, escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_req_i | input | 1 | Start-of-cell request, one-cycle pulse |
| in_valid_i | input | 1 | Input nibble valid |
| in_ready_o | output | 1 | Input nibble accepted when high together with valid |
| in_kind_i | input | 2 | Input kind tag (00 data, 01 escape, 10 code) |
| in_nib_i | input | NIB_W | Input nibble |
| out_valid_o | output | 1 | Output nibble valid |
| out_kind_o | output | 2 | Output kind tag, same encoding as the input |
| out_nib_o | output | NIB_W | Output nibble, scrambled when it is data |

## Verification
The assertions rely on three things about the input side. A start-of-cell request is a single-cycle pulse and is never raised while an inserted command is still being emitted. Upstream commands arrive as complete escape-then-code pairs. The reserved kind value 2'b11 never appears. The bench drives every request through one task that lowers the request after one cycle and waits out the second nibble. It sends escapes only as part of a pair, or in the deliberate escape-escape-escape-8 run that follows an inserted reseed.

// File: rtl/nscr_pkg.sv
package nscr_pkg;
  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_ESC  = 2'b01,
    KIND_CODE = 2'b10
  } nib_kind_e;

  // code nibble of the ordinary start-of-cell command
  localparam int unsigned SOC_CODE_VAL = 4;
endpackage

// File: rtl/nscr_lfsr.sv
module nscr_lfsr #(
  parameter int unsigned LFSR_W = 10,
  parameter int unsigned TAP    = 7,
  parameter int unsigned NIB_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             reload_i,
  output logic [NIB_W-1:0] mask_o,
  output logic             period_done_o
);
  localparam int unsigned PERIOD = (1 << LFSR_W) - 1;
  localparam int unsigned CNT_W  = $clog2(PERIOD + 1);

  logic [LFSR_W-1:0] lfsr_q, lfsr_adv;
  logic [CNT_W-1:0]  cnt_q;

  // lfsr_q[LFSR_W-1] is the newest sequence bit
  always_comb begin
    lfsr_adv = lfsr_q;
    for (int k = 0; k < int'(NIB_W); k++) begin
      lfsr_adv = {lfsr_adv[LFSR_W-TAP] ^ lfsr_adv[0], lfsr_adv[LFSR_W-1:1]};
    end
  end

  for (genvar i = 0; i < NIB_W; i++) begin : g_mask
    assign mask_o[i] = lfsr_q[LFSR_W-1-i];
  end

  // counter saturates at PERIOD; reset value forces a reseed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= '1;
      cnt_q  <= CNT_W'(PERIOD);
    end else if (reload_i) begin
      lfsr_q <= '1;
      cnt_q  <= '0;
    end else if (adv_i) begin
      lfsr_q <= lfsr_adv;
      if (cnt_q != CNT_W'(PERIOD)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign period_done_o = (cnt_q == CNT_W'(PERIOD));

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R2

  AST_PERIOD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !reload_i && cnt_q == CNT_W'(PERIOD - 1)) |=> (lfsr_q == '1)); // R9
endmodule

// File: rtl/nscr_sof_seq.sv
module nscr_sof_seq
  import nscr_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             period_done_i,
  output logic             busy_o,
  output logic             emit_o,
  output nib_kind_e        kind_o,
  output logic [NIB_W-1:0] nib_o
);
  typedef enum logic {SEQ_IDLE, SEQ_TAIL} seq_state_e;
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    emit_o  = 1'b0;
    kind_o  = KIND_ESC;
    nib_o   = '0;
    unique case (state_q)
      SEQ_IDLE: if (req_i) begin
        emit_o  = 1'b1;
        state_d = SEQ_TAIL;
      end
      SEQ_TAIL: begin
        emit_o  = 1'b1;
        state_d = SEQ_IDLE;
        if (!period_done_i) begin
          kind_o = KIND_CODE;
          nib_o  = NIB_W'(SOC_CODE_VAL);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == SEQ_TAIL);

  AST_TAIL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && req_i) |=> (emit_o && busy_o)); // R4
endmodule

// File: rtl/cmd_nib_scrambler.sv
module cmd_nib_scrambler
  import nscr_pkg::*;
#(
  parameter int unsigned LFSR_W   = 10,
  parameter int unsigned LFSR_TAP = 7,
  parameter int unsigned NIB_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_req_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       in_kind_i,
  input  logic [NIB_W-1:0] in_nib_i,
  output logic             out_valid_o,
  output logic [1:0]       out_kind_o,
  output logic [NIB_W-1:0] out_nib_o
);
  logic             seq_busy, seq_emit, period_done, accept, emit, reload;
  nib_kind_e        seq_kind, sel_kind, out_kind_q;
  logic [NIB_W-1:0] seq_nib, sel_nib, mask, scr_nib, out_nib_q;
  logic             out_valid_q, prev_esc_q;

  nscr_sof_seq #(.NIB_W(NIB_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (sof_req_i),
    .period_done_i (period_done),
    .busy_o        (seq_busy),
    .emit_o        (seq_emit),
    .kind_o        (seq_kind),
    .nib_o         (seq_nib)
  );

  nscr_lfsr #(.LFSR_W(LFSR_W), .TAP(LFSR_TAP), .NIB_W(NIB_W)) u_lfsr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .adv_i         (emit),
    .reload_i      (reload),
    .mask_o        (mask),
    .period_done_o (period_done)
  );

  // a pending or running start-of-cell command owns the output slot
  assign in_ready_o = !seq_busy && !sof_req_i;
  assign accept     = in_valid_i && in_ready_o;
  assign emit       = seq_emit || accept;

  always_comb begin
    if (seq_emit) begin
      sel_kind = seq_kind;
      sel_nib  = seq_nib;
    end else begin
      sel_kind = nib_kind_e'(in_kind_i);
      sel_nib  = in_nib_i;
    end
  end

  assign scr_nib = (sel_kind == KIND_DATA) ? (sel_nib ^ mask) : sel_nib;
  assign reload  = emit && (sel_kind == KIND_ESC) && prev_esc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_kind_q  <= KIND_DATA;
      out_nib_q   <= '0;
      prev_esc_q  <= 1'b0;
    end else begin
      out_valid_q <= emit;
      if (emit) begin
        out_kind_q <= sel_kind;
        out_nib_q  <= scr_nib;
        prev_esc_q <= (sel_kind == KIND_ESC);
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_kind_o  = out_kind_q;
  assign out_nib_o   = out_nib_q;

  AST_DATA_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_kind_i == 2'b00) |=> (out_valid_o && out_kind_o == 2'b00)); // R1

  AST_CMD_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_kind_i != 2'b00) |=>
      (out_nib_o == $past(in_nib_i) && out_kind_o == $past(in_kind_i))); // R3

  AST_SOF_ESC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_req_i && !seq_busy) |=> (out_valid_o && out_kind_o == 2'b01 && !in_ready_o)); // R4
endmodule

// File: tb/cmd_nib_scrambler_test.sv
`timescale 1ns/1ps
module cmd_nib_scrambler_test;
  localparam logic [1:0] K_DATA = 2'b00, K_ESC = 2'b01, K_CODE = 2'b10;
  localparam int NV = 9;
  // {req, valid, kind[1:0], nib[3:0], exp_valid, exp_kind[1:0], exp_nib[3:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b0, K_DATA, 4'h0, 1'b1, K_ESC,  4'h0},
    {1'b0, 1'b0, K_DATA, 4'h0, 1'b1, K_ESC,  4'h0},
    {1'b0, 1'b1, K_DATA, 4'h0, 1'b1, K_DATA, 4'hF},
    {1'b0, 1'b1, K_DATA, 4'h5, 1'b1, K_DATA, 4'h5},
    {1'b0, 1'b1, K_DATA, 4'hA, 1'b1, K_DATA, 4'hB},
    {1'b0, 1'b1, K_DATA, 4'h3, 1'b1, K_DATA, 4'hF},
    {1'b0, 1'b0, K_DATA, 4'h0, 1'b0, K_DATA, 4'h0},
    {1'b0, 1'b1, K_ESC,  4'hA, 1'b1, K_ESC,  4'hA},
    {1'b0, 1'b1, K_CODE, 4'h8, 1'b1, K_CODE, 4'h8}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sof_req = 1'b0, in_valid = 1'b0;
  logic [1:0] in_kind = 2'b00;
  logic [3:0] in_nib = 4'h0;
  logic       in_ready_o, out_valid_o;
  logic [1:0] out_kind_o;
  logic [3:0] out_nib_o;
  int n_chk = 0, n_fail = 0;

  // bench model: m_r[k] holds X(t-k)
  logic [9:0] m_r;
  int         m_cnt;
  bit         m_pesc;

  always #2 clk = ~clk;

  cmd_nib_scrambler uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_req_i(sof_req), .in_valid_i(in_valid),
    .in_ready_o(in_ready_o), .in_kind_i(in_kind), .in_nib_i(in_nib),
    .out_valid_o(out_valid_o), .out_kind_o(out_kind_o), .out_nib_o(out_nib_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_r = '1; m_cnt = 1023; m_pesc = 1'b0;
  endfunction

  function automatic void m_step(input logic [1:0] k);
    if (k == K_ESC && m_pesc) begin
      m_r = '1; m_cnt = 0;
    end else begin
      for (int j = 0; j < 4; j++) m_r = {m_r[8:0], m_r[6] ^ m_r[9]};
      if (m_cnt < 1023) m_cnt++;
    end
    m_pesc = (k == K_ESC);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(out_valid_o == 1'b0, "R8", "valid in reset", out_valid_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_reset();
  endtask

  task automatic put_nib(input logic [1:0] k, input logic [3:0] v, input string req);
    logic [3:0] e;
    in_valid = 1'b1; in_kind = k; in_nib = v;
    #1;
    chk(in_ready_o == 1'b1, "R4", "ready idle", in_ready_o, 1);
    @(negedge clk);
    in_valid = 1'b0;
    e = (k == K_DATA) ? (v ^ m_r[3:0]) : v;
    chk(out_valid_o == 1'b1, req, "valid", out_valid_o, 1);
    chk(out_kind_o == k, req, "kind", out_kind_o, k);
    chk(out_nib_o == e, req, "nibble", out_nib_o, e);
    m_step(k);
  endtask

  task automatic do_sof(input bit reseed, input string req);
    sof_req = 1'b1;
    #1;
    chk(in_ready_o == 1'b0, "R4", "ready on request", in_ready_o, 0);
    @(negedge clk);
    sof_req = 1'b0;
    chk(out_valid_o && out_kind_o == K_ESC && out_nib_o == 4'h0, "R4", "first escape",
        {out_valid_o, out_kind_o, out_nib_o}, {1'b1, K_ESC, 4'h0});
    m_step(K_ESC);
    #1;
    chk(in_ready_o == 1'b0, "R4", "ready while busy", in_ready_o, 0);
    @(negedge clk);
    if (reseed) begin
      chk(out_valid_o && out_kind_o == K_ESC && out_nib_o == 4'h0, req, "second escape",
          {out_valid_o, out_kind_o, out_nib_o}, {1'b1, K_ESC, 4'h0});
      m_step(K_ESC);
    end else begin
      chk(out_valid_o && out_kind_o == K_CODE && out_nib_o == 4'h4, req, "code 4",
          {out_valid_o, out_kind_o, out_nib_o}, {1'b1, K_CODE, 4'h4});
      m_step(K_CODE);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid_o == 1'b0, "R8", "valid in reset", out_valid_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: reseed after reset, first masks, pass-through
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i < 2) ? "R8" : (i >= 7) ? "R3" : (i == 6) ? "R2" : "R6";
      {sof_req, in_valid, in_kind, in_nib} = VEC[i][14:7];
      @(negedge clk);
      sof_req = 1'b0; in_valid = 1'b0;
      chk(out_valid_o == VEC[i][6], tag, "table valid", out_valid_o, VEC[i][6]);
      if (VEC[i][6])
        chk({out_kind_o, out_nib_o} == VEC[i][5:0], tag, "table kind/nibble",
            {out_kind_o, out_nib_o}, VEC[i][5:0]);
    end

    // mid-run reset forces reseed, first data uses 1111
    do_reset();
    do_sof(1'b1, "R8");
    put_nib(K_DATA, 4'h0, "R6");
    put_nib(K_DATA, 4'h9, "R1");

    // escape run into timing marker
    do_reset();
    do_sof(1'b1, "R5");
    put_nib(K_ESC, 4'h0, "R7");
    put_nib(K_CODE, 4'h8, "R7");
    put_nib(K_DATA, 4'h7, "R7");
    chk(out_nib_o == 4'h7, "R7", "data after marker", out_nib_o, 7);

    // idle cycles do not move the generator
    do_reset();
    do_sof(1'b1, "R5");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid_o == 1'b0, "R2", "idle valid", out_valid_o, 0);
    end
    put_nib(K_DATA, 4'h0, "R2");
    chk(out_nib_o == 4'hF, "R2", "mask held over idle", out_nib_o, 4'hF);

    // request while data is waiting: data held off, command first
    put_nib(K_DATA, 4'h1, "R1");
    sof_req = 1'b1; in_valid = 1'b1; in_kind = K_DATA; in_nib = 4'h3;
    #1;
    chk(in_ready_o == 1'b0, "R4", "ready with request", in_ready_o, 0);
    @(negedge clk);
    sof_req = 1'b0;
    chk(out_kind_o == K_ESC, "R4", "escape before data", out_kind_o, K_ESC);
    m_step(K_ESC);
    @(negedge clk);
    chk(out_kind_o == K_CODE && out_nib_o == 4'h4, "R5", "short cell command",
        {out_kind_o, out_nib_o}, {K_CODE, 4'h4});
    m_step(K_CODE);
    in_valid = 1'b0;
    put_nib(K_DATA, 4'h3, "R2");

    // full period: 1021 data, then code-4 cell, then wrap and forced reseed
    do_reset();
    do_sof(1'b1, "R5");
    for (int i = 0; i < 1021; i++) put_nib(K_DATA, 4'((i * 7 + 3) & 15), "R1");
    do_sof(1'b0, "R5");
    put_nib(K_DATA, 4'h6, "R9");
    chk(out_nib_o == 4'h9, "R9", "mask back to ones", out_nib_o, 9);
    do_sof(1'b1, "R10");
    put_nib(K_DATA, 4'hC, "R6");
    chk(out_nib_o == 4'h3, "R6", "mask after reseed", out_nib_o, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule